// File: doc/BRIEF.md
# Shadowed Interrupt Aggregator for a USB OTG Controller

This block collects the interrupt events of a USB on-the-go controller into one 32-bit pending register. The events are per-endpoint transmit completions, per-endpoint receive completions, eight core bus events and a VBUS-drive change event. It keeps an enable mask beside that register. Software never writes either register directly. It sets bits through a set alias and clears them through a clear alias. Through the set alias it can also inject an event, for example to force a VBUS-drive event that starts a polling loop.

Software sees a masked view that reads as pending AND mask. A single level interrupt line is driven from that view. Once the line has fired, it is held off until software writes the end-of-interrupt register. That write re-arms the line, so work left pending always produces a fresh rising edge. A soft-reset bit clears all pending and enable state, and a fixed nonzero identification word is readable so software can check that the block is clocked. Access is a plain 32-bit register port with combinational read data. Hardware event inputs are one-cycle pulses.

Top module: `otg_irq_shadow`

## Requirements
- R1: After reset, offsets 0x20, 0x2C and 0x38 read 0, `irq_o` is low, and offset 0x00 reads the nonzero parameter `REVISION`.
- R2: Each hardware event pulse sets its pending bit on the next clock edge, and the bit stays set. The bit positions are: `tx_evt[i]` at bit i (bits 4:0), `rx_evt[j]` at bit 9+j (bits 12:9), `core_evt[k]` at bit 16+k (bits 23:16) and `vbus_drv_evt` at bit 24.
- R3: A write to offset 0x24 sets the pending bits at the positions where the data has ones. A write to offset 0x28 clears the pending bits at those positions. All other pending bits keep their values.
- R4: If a hardware event pulse and a write to 0x28 hit the same bit in the same cycle, the bit ends up set. Other bits named in that write are still cleared.
- R5: A write to offset 0x30 sets enable bits and a write to offset 0x34 clears them. Offset 0x2C reads the enable mask.
- R6: Offset 0x38 reads pending AND mask. Pending bits that are not enabled never raise `irq_o`.
- R7: Bits 31:25, 15:13 and 8:5 are reserved. They read 0 in the pending, mask and masked views and ignore writes to every alias.
- R8: Writes to offsets 0x20 and 0x2C change neither the pending register nor the mask.
- R9: While armed, `irq_o` rises on the clock edge after the masked view first becomes nonzero. It disarms on that same edge. Reset leaves the line armed.
- R10: While disarmed, `irq_o` does not rise again. A write of any value to offset 0x3C drives `irq_o` low on the next edge and re-arms it, so a nonzero masked view raises it one edge after that.
- R11: `irq_o` falls on the clock edge after the masked view becomes zero.
- R12: A write to offset 0x04 with bit 0 set clears the pending register and the mask, drives `irq_o` low and re-arms the line. The same write with bit 0 clear changes nothing. Offset 0x04 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when high, read when low |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| tx_evt | input | 5 | Transmit endpoint event pulses, endpoint 0 first |
| rx_evt | input | 4 | Receive event pulses for endpoints 1 to 4 |
| core_evt | input | 8 | Core bus event pulses |
| vbus_drv_evt | input | 1 | VBUS-drive change event pulse |
| irq_o | output | 1 | Level interrupt line |

## Verification
Register writes and event pulses take effect on the edge that samples them, so a readback on the following falling edge already shows the new pending and mask values. The interrupt line adds one more register: it changes one edge after the pending or mask change that causes it, and one edge after an end-of-interrupt or soft-reset write. Each scenario therefore samples the line twice, once on the falling edge right after the causing write and once a full cycle later. The first sample proves the line has not moved early and the second proves it moved on time. In the disarmed case the line is held off over several cycles before the end-of-interrupt write.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

   localparam int DATA_W = 32;
   localparam int ADDR_W = 8;

   localparam logic [ADDR_W-1:0] OFF_IDENT    = 8'h00;
   localparam logic [ADDR_W-1:0] OFF_CTRL     = 8'h04;
   localparam logic [ADDR_W-1:0] OFF_PEND     = 8'h20;
   localparam logic [ADDR_W-1:0] OFF_PEND_SET = 8'h24;
   localparam logic [ADDR_W-1:0] OFF_PEND_CLR = 8'h28;
   localparam logic [ADDR_W-1:0] OFF_ENA      = 8'h2C;
   localparam logic [ADDR_W-1:0] OFF_ENA_SET  = 8'h30;
   localparam logic [ADDR_W-1:0] OFF_ENA_CLR  = 8'h34;
   localparam logic [ADDR_W-1:0] OFF_VIEW     = 8'h38;
   localparam logic [ADDR_W-1:0] OFF_ACK      = 8'h3C;

   typedef struct packed {
      logic pend_set;
      logic pend_clr;
      logic ena_set;
      logic ena_clr;
      logic ack;
      logic sreset;
   } wr_strobe_t;

   // Ones at bits lsb .. lsb+n-1 of a data word.
   function automatic logic [DATA_W-1:0] span(input int lsb, input int n);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i >= lsb && i < lsb + n) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/irqagg_pend_bank.sv
module irqagg_pend_bank
   import irqagg_pkg::*;
#(
   parameter int                W    = DATA_W,
   parameter logic [DATA_W-1:0] IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sreset,
   input  logic [W-1:0] hw_set,
   input  logic         sw_set,
   input  logic         sw_clr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] pend_q
);

   generate
      if (W > DATA_W) begin : g_bad_w
         $error("irqagg_pend_bank: W exceeds the data width");
      end
   endgenerate

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (IMPL[i]) begin : g_flop
         logic nxt;
         always_comb begin
            nxt = pend_q[i];
            if (sw_clr && wdata[i]) nxt = 1'b0;
            if (sw_set && wdata[i]) nxt = 1'b1;
            if (hw_set[i])          nxt = 1'b1;
            if (sreset)             nxt = 1'b0;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q[i] <= 1'b0;
            else        pend_q[i] <= nxt;
         end
      end else begin : g_rsvd
         assign pend_q[i] = 1'b0;
      end
   end

   // R2 R4
   property p_hw_wins;
      @(posedge clk) disable iff (!rst_n)
         (|(hw_set & IMPL[W-1:0]) && !sreset) |=>
            ((pend_q & $past(hw_set & IMPL[W-1:0])) == $past(hw_set & IMPL[W-1:0]));
   endproperty
   hw_set_wins_chk: assert property (p_hw_wins);

   // R3
   property p_sw_clr;
      @(posedge clk) disable iff (!rst_n)
         (sw_clr && hw_set == '0 && !sreset) |=> ((pend_q & $past(wdata)) == '0);
   endproperty
   sw_clear_chk: assert property (p_sw_clr);

endmodule

// File: rtl/irqagg_ena_bank.sv
module irqagg_ena_bank
   import irqagg_pkg::*;
#(
   parameter int                W    = DATA_W,
   parameter logic [DATA_W-1:0] IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sreset,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] ena_q
);

   localparam logic [W-1:0] KEEP = IMPL[W-1:0];

   logic [W-1:0] ena_d;

   always_comb begin
      ena_d = ena_q;
      if (clr_we) ena_d = ena_d & ~wdata;
      if (set_we) ena_d = ena_d | wdata;
      if (sreset) ena_d = '0;
      ena_d = ena_d & KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ena_q <= '0;
      else        ena_q <= ena_d;
   end

   // R5
   property p_set;
      @(posedge clk) disable iff (!rst_n)
         (set_we && !sreset) |=> ((ena_q & $past(wdata & KEEP)) == $past(wdata & KEEP));
   endproperty
   ena_set_chk: assert property (p_set);

   // R5
   property p_clr;
      @(posedge clk) disable iff (!rst_n)
         (clr_we && !set_we && !sreset) |=> ((ena_q & $past(wdata)) == '0);
   endproperty
   ena_clr_chk: assert property (p_clr);

   // R8
   property p_hold;
      @(posedge clk) disable iff (!rst_n)
         (!set_we && !clr_we && !sreset) |=> $stable(ena_q);
   endproperty
   ena_hold_chk: assert property (p_hold);

endmodule

// File: rtl/irqagg_arm_ctrl.sv
module irqagg_arm_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic sreset,
   input  logic ack,
   input  logic pending,
   output logic irq_o
);

   logic armed_q;
   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         irq_q   <= 1'b0;
      end else if (sreset || ack) begin
         armed_q <= 1'b1;
         irq_q   <= 1'b0;
      end else if (armed_q && pending) begin
         armed_q <= 1'b0;
         irq_q   <= 1'b1;
      end else if (!pending) begin
         irq_q   <= 1'b0;
      end
   end

   assign irq_o = irq_q;

   // R9
   property p_fire;
      @(posedge clk) disable iff (!rst_n)
         (armed_q && pending && !ack && !sreset) |=> irq_o;
   endproperty
   fire_when_armed_chk: assert property (p_fire);

   // R10
   property p_no_refire;
      @(posedge clk) disable iff (!rst_n)
         (!armed_q && !irq_o) |=> !irq_o;
   endproperty
   held_off_chk: assert property (p_no_refire);

   // R10
   property p_ack_low;
      @(posedge clk) disable iff (!rst_n)
         ack |=> !irq_o;
   endproperty
   ack_drops_chk: assert property (p_ack_low);

   // R11
   property p_idle_low;
      @(posedge clk) disable iff (!rst_n)
         !pending |=> !irq_o;
   endproperty
   idle_low_chk: assert property (p_idle_low);

endmodule

// File: rtl/otg_irq_shadow.sv
module otg_irq_shadow
   import irqagg_pkg::*;
#(
   parameter int                NUM_TX   = 5,
   parameter int                NUM_RX   = 4,
   parameter int                NUM_CORE = 8,
   parameter int                TX_LSB   = 0,
   parameter int                RX_LSB   = 9,
   parameter int                CORE_LSB = 16,
   parameter logic [DATA_W-1:0] REVISION = 32'h0001_0203
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_sel,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [NUM_TX-1:0]   tx_evt,
   input  logic [NUM_RX-1:0]   rx_evt,
   input  logic [NUM_CORE-1:0] core_evt,
   input  logic                vbus_drv_evt,
   output logic                irq_o
);

   localparam int VBUS_BIT = CORE_LSB + NUM_CORE;
   localparam logic [DATA_W-1:0] IMPL =
      span(TX_LSB, NUM_TX) | span(RX_LSB, NUM_RX) | span(CORE_LSB, NUM_CORE + 1);

   generate
      if (NUM_TX < 1 || NUM_RX < 1 || NUM_CORE < 1) begin : g_bad_cnt
         $error("otg_irq_shadow: every event group needs at least one line");
      end
      if (TX_LSB + NUM_TX > RX_LSB) begin : g_bad_tx
         $error("otg_irq_shadow: transmit field overlaps receive field");
      end
      if (RX_LSB + NUM_RX > CORE_LSB) begin : g_bad_rx
         $error("otg_irq_shadow: receive field overlaps core field");
      end
      if (VBUS_BIT >= DATA_W) begin : g_bad_core
         $error("otg_irq_shadow: core field exceeds the data word");
      end
      if (REVISION == '0) begin : g_bad_rev
         $error("otg_irq_shadow: identification word must be nonzero");
      end
   endgenerate

   // Register write decode
   wr_strobe_t stb;
   logic       wr;

   assign wr = reg_sel && reg_we;

   always_comb begin
      stb          = '0;
      stb.pend_set = wr && (reg_addr == OFF_PEND_SET);
      stb.pend_clr = wr && (reg_addr == OFF_PEND_CLR);
      stb.ena_set  = wr && (reg_addr == OFF_ENA_SET);
      stb.ena_clr  = wr && (reg_addr == OFF_ENA_CLR);
      stb.ack      = wr && (reg_addr == OFF_ACK);
      stb.sreset   = wr && (reg_addr == OFF_CTRL) && reg_wdata[0];
   end

   // Hardware events placed at their source positions
   logic [DATA_W-1:0] hw_vec;

   always_comb begin
      hw_vec                     = '0;
      hw_vec[TX_LSB +: NUM_TX]   = tx_evt;
      hw_vec[RX_LSB +: NUM_RX]   = rx_evt;
      hw_vec[CORE_LSB +: NUM_CORE] = core_evt;
      hw_vec[VBUS_BIT]           = vbus_drv_evt;
   end

   logic [DATA_W-1:0] pend_q;
   logic [DATA_W-1:0] ena_q;
   logic [DATA_W-1:0] view;

   irqagg_pend_bank #(
      .W    (DATA_W),
      .IMPL (IMPL)
   ) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .sreset (stb.sreset),
      .hw_set (hw_vec),
      .sw_set (stb.pend_set),
      .sw_clr (stb.pend_clr),
      .wdata  (reg_wdata),
      .pend_q (pend_q)
   );

   irqagg_ena_bank #(
      .W    (DATA_W),
      .IMPL (IMPL)
   ) u_ena (
      .clk    (clk),
      .rst_n  (rst_n),
      .sreset (stb.sreset),
      .set_we (stb.ena_set),
      .clr_we (stb.ena_clr),
      .wdata  (reg_wdata),
      .ena_q  (ena_q)
   );

   assign view = pend_q & ena_q;

   irqagg_arm_ctrl u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .sreset  (stb.sreset),
      .ack     (stb.ack),
      .pending (|view),
      .irq_o   (irq_o)
   );

   // Read mux: aliases read back the register they modify
   always_comb begin
      unique case (reg_addr)
         OFF_IDENT:                          reg_rdata = REVISION;
         OFF_PEND, OFF_PEND_SET, OFF_PEND_CLR: reg_rdata = pend_q;
         OFF_ENA, OFF_ENA_SET, OFF_ENA_CLR:  reg_rdata = ena_q;
         OFF_VIEW:                           reg_rdata = view;
         default:                            reg_rdata = '0;
      endcase
   end

   // R12
   property p_sreset;
      @(posedge clk) disable iff (!rst_n)
         stb.sreset |=> (pend_q == '0 && ena_q == '0 && !irq_o);
   endproperty
   soft_reset_chk: assert property (p_sreset);

   // R8
   property p_direct_ignored;
      @(posedge clk) disable iff (!rst_n)
         (wr && reg_addr == OFF_PEND && hw_vec == '0) |=> $stable(pend_q);
   endproperty
   direct_write_chk: assert property (p_direct_ignored);

endmodule

// File: tb/otg_irq_shadow_bench.sv
module otg_irq_shadow_bench;

   localparam logic [31:0] REV  = 32'h0001_0203;
   localparam logic [31:0] IMPL = 32'h01FF_1E1F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [4:0]  tx_evt = '0;
   logic [3:0]  rx_evt = '0;
   logic [7:0]  core_evt = '0;
   logic        vbus_drv_evt = 1'b0;
   logic        irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   otg_irq_shadow #(.REVISION(REV)) u_otg_irq_shadow (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_sel      (reg_sel),
      .reg_we       (reg_we),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .tx_evt       (tx_evt),
      .rx_evt       (rx_evt),
      .core_evt     (core_evt),
      .vbus_drv_evt (vbus_drv_evt),
      .irq_o        (irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_sel = 1'b0; reg_we = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic pulse(input logic [4:0] t, input logic [3:0] r,
                        input logic [7:0] c, input logic v);
      tx_evt = t; rx_evt = r; core_evt = c; vbus_drv_evt = v;
      @(posedge clk);
      @(negedge clk);
      tx_evt = '0; rx_evt = '0; core_evt = '0; vbus_drv_evt = 1'b0;
   endtask

   task automatic t_reset;
      rd("R1 pending", 8'h20, 32'h0);
      rd("R1 mask", 8'h2C, 32'h0);
      rd("R1 view", 8'h38, 32'h0);
      chk("R1 irq", {31'b0, irq_o}, 32'h0);
      rd("R1 ident", 8'h00, REV);
   endtask

   task automatic t_layout;
      pulse(5'b10101, 4'h0, 8'h00, 1'b0);
      rd("R2 tx bits", 8'h20, 32'h0000_0015);
      tick(2);
      rd("R2 sticky", 8'h20, 32'h0000_0015);
      wr(8'h28, 32'hFFFF_FFFF);
      pulse(5'b0, 4'b1001, 8'h00, 1'b0);
      rd("R2 rx bits", 8'h20, 32'h0000_1200);
      wr(8'h28, 32'hFFFF_FFFF);
      pulse(5'b0, 4'h0, 8'h81, 1'b0);
      rd("R2 core bits", 8'h20, 32'h0081_0000);
      wr(8'h28, 32'hFFFF_FFFF);
      pulse(5'b0, 4'h0, 8'h00, 1'b1);
      rd("R2 vbus bit", 8'h20, 32'h0100_0000);
      wr(8'h28, 32'hFFFF_FFFF);
   endtask

   task automatic t_set_clear;
      wr(8'h24, 32'hFFFF_FFFF);
      rd("R3 R7 set all", 8'h20, IMPL);
      wr(8'h28, 32'h0000_000F);
      rd("R3 partial clear", 8'h20, IMPL & ~32'h0000_000F);
      wr(8'h28, 32'hFFFF_FFFF);
      rd("R3 clear all", 8'h20, 32'h0);
   endtask

   task automatic t_race;
      wr(8'h24, 32'h0000_0003);
      tx_evt = 5'b00010;
      reg_sel = 1'b1; reg_we = 1'b1; reg_addr = 8'h28; reg_wdata = 32'h3;
      @(posedge clk);
      @(negedge clk);
      reg_sel = 1'b0; reg_we = 1'b0; tx_evt = '0;
      rd("R4 set wins", 8'h20, 32'h0000_0002);
   endtask

   task automatic t_mask;
      wr(8'h30, 32'hFFFF_FFFF);
      rd("R5 R7 mask set", 8'h2C, IMPL);
      wr(8'h34, 32'h00FF_0000);
      rd("R5 mask clear", 8'h2C, 32'h0100_1E1F);
      wr(8'h2C, 32'h0);
      rd("R8 mask direct", 8'h2C, 32'h0100_1E1F);
      wr(8'h20, 32'hFFFF_FFFF);
      rd("R8 pending direct", 8'h20, 32'h0000_0002);
      rd("R6 view", 8'h38, 32'h0000_0002);
      wr(8'h24, 32'h01FF_0000);
      rd("R6 view wide", 8'h38, 32'h0100_0002);
   endtask

   task automatic t_soft_reset;
      wr(8'h04, 32'h0000_0002);
      rd("R12 bit0 clear pending", 8'h20, 32'h01FF_0002);
      rd("R12 bit0 clear mask", 8'h2C, 32'h0100_1E1F);
      wr(8'h04, 32'h0000_0001);
      rd("R12 pending", 8'h20, 32'h0);
      rd("R12 mask", 8'h2C, 32'h0);
      chk("R12 irq", {31'b0, irq_o}, 32'h0);
      rd("R12 ctrl read", 8'h04, 32'h0);
   endtask

   task automatic t_irq_cycle;
      wr(8'h30, 32'h1);
      wr(8'h24, 32'h1);
      chk("R9 not early", {31'b0, irq_o}, 32'h0);
      tick(1);
      chk("R9 rise", {31'b0, irq_o}, 32'h1);
      wr(8'h28, 32'h1);
      chk("R11 not early", {31'b0, irq_o}, 32'h1);
      tick(1);
      chk("R11 fall", {31'b0, irq_o}, 32'h0);
      wr(8'h24, 32'h1);
      tick(3);
      chk("R10 held off", {31'b0, irq_o}, 32'h0);
      wr(8'h3C, 32'hDEAD_BEEF);
      chk("R10 after ack", {31'b0, irq_o}, 32'h0);
      tick(1);
      chk("R10 refire", {31'b0, irq_o}, 32'h1);
      wr(8'h3C, 32'h0);
      chk("R10 ack drops", {31'b0, irq_o}, 32'h0);
      tick(1);
      chk("R10 pending refire", {31'b0, irq_o}, 32'h1);
      wr(8'h28, 32'h1);
      tick(1);
      chk("R11 idle", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_masked_off;
      wr(8'h04, 32'h1);
      wr(8'h24, 32'h0001_0000);
      tick(2);
      chk("R6 disabled no irq", {31'b0, irq_o}, 32'h0);
      rd("R6 view zero", 8'h38, 32'h0);
      wr(8'h30, 32'h0001_0000);
      chk("R9 enable not early", {31'b0, irq_o}, 32'h0);
      tick(1);
      chk("R9 enable rise", {31'b0, irq_o}, 32'h1);
   endtask

   task automatic report;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_layout();
      t_set_clear();
      t_race();
      t_mask();
      t_soft_reset();
      t_irq_cycle();
      t_masked_off();
      done = 1'b1;
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         report();
      end
   end

endmodule